// File: doc/BRIEF.md
# Dual-Window I/O Register Bank

This block is the peripheral register file that sits between a small processor core and its peripherals. It holds 64 byte-wide registers, and the core reaches them in two ways. Direct I/O operations use register numbers 0x00 to 0x3F. Load and store operations on data memory see the same registers shifted up by 0x20, so they use 0x20 to 0x5F. The lower half of the space also accepts single-bit set, clear and test operations.

A fixed attribute layout gives every bit one of four kinds:
- ordinary read/write;
- read-only, loaded by the peripheral;
- status flag, which the peripheral raises and software clears by writing a one;
- reserved.

A single-bit operation changes only the bit it names. It therefore never clears a neighbouring flag by accident. Writes to reserved registers are refused and reported on a one-cycle error strobe.

The core issues at most one request per cycle on the request port. The peripherals use a separate side port to raise flags and to load read-only bits.

Top module: `dwio_top`

## Requirements
- R1: Operation codes on `req_op` are: 0 I/O read, 1 I/O write, 2 data read, 3 data write, 4 bit set, 5 bit clear, 6 bit test, 7 no operation. An I/O read or write accepts `req_addr` from 0x00 to 0x3F. A read raises `rd_valid` for one cycle on the next clock edge, with the register byte on `rd_data`. I/O addresses of 0x40 and above are ignored without any response.
- R2: A data read or write at address A in 0x20..0x5F reaches I/O register A-0x20. This is the same storage as the direct path.
- R3: A data access outside 0x20..0x5F gives no `rd_valid`, no `err_strobe`, and changes no register.
- R4: Bit set and bit clear apply only to I/O addresses 0x00..0x1F, at bit `req_bit`. All other bits of that register keep their value. A bit operation (set, clear or test) at address 0x20 or above raises `err_strobe` on the next edge, gives no read response, and changes nothing.
- R5: A bit test at 0x00..0x1F raises `rd_valid` and `tst_valid` together on the next edge. `tst_bit` equals bit `req_bit` of the `rd_data` byte returned.
- R6: Registers at I/O addresses with low nibble 0x8 are flag registers with this bit layout:
  - bits 7..4: status flags;
  - bits 3..2: read/write;
  - bit 1: read-only;
  - bit 0: reserved.
  
  A full-byte write clears each flag written as one, leaves each flag written as zero unchanged, and loads the read/write bits.
- R7: A bit set on a flag bit clears that flag only. A bit clear on a flag bit has no effect.
- R8: Reserved bits always read as zero. Registers with low nibble 0xE have bits 7..6 reserved and bits 5..0 read/write.
- R9: I/O addresses whose low nibble is 0xF are reserved registers.
  - A full write, bit set or bit clear to them, by either path, changes nothing and raises `err_strobe` for exactly one cycle on the next edge.
  - Reads and bit tests of them return zero without error.
- R10: On a cycle with a peripheral flag-set pulse, each flag bit set in `hw_flag_set` at register `hw_addr` becomes one. The set wins over a software clear of the same flag in the same cycle.
- R11: Registers with low nibble 0x9 are entirely read-only. Read-only bits ignore all core writes. They take `hw_ro_data` when `hw_ro_load` is high for `hw_addr`.
- R12: After reset every register reads zero, and `rd_valid`, `tst_valid` and `err_strobe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core request present this cycle |
| req_op | input | 3 | Operation code (see R1) |
| req_addr | input | DM_ADDR_W (16) | I/O address, or data address for data operations |
| req_bit | input | 3 | Bit index for bit operations |
| req_wdata | input | 8 | Full-byte write value |
| hw_addr | input | 6 | Register targeted by the peripheral side port |
| hw_flag_set | input | 8 | Per-bit flag set pulses |
| hw_ro_load | input | 1 | Load read-only bits of `hw_addr` |
| hw_ro_data | input | 8 | Value for read-only bits |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Register byte read |
| tst_valid | output | 1 | Bit test result valid |
| tst_bit | output | 1 | Value of the tested bit |
| err_strobe | output | 1 | One-cycle report of a refused request |

## Verification
Every response, whether read byte, test bit or error strobe, is due exactly one clock edge after the cycle that carries the request. A register update shows up on any later read.

The bench drives each request on a falling edge, holds it for one cycle, and samples all outputs at the next falling edge. It then idles one cycle, so a response is never confused with the following request.

Effects on storage, including effects that must not happen, are checked by later reads through either window. These reads are compared against a bench model built from the attribute layout in the requirements. The model covers directed flag, reserved-address and set-versus-clear cases and a long seeded random mix.

// File: rtl/dwio_pkg.sv
// Package: shared widths, operation codes and the per-bit attribute layout
// of the register bank. Assumes an 8-bit, 64-entry space.
package dwio_pkg;
    localparam int IO_DATA_W = 8;
    localparam int IO_REGS   = 64;
    localparam int IO_ADDR_W = $clog2(IO_REGS);
    localparam int IO_BIT_W  = $clog2(IO_DATA_W);

    typedef logic [IO_DATA_W-1:0] byte_t;

    typedef enum logic [2:0] {
        OP_IO_RD = 3'd0,
        OP_IO_WR = 3'd1,
        OP_DM_RD = 3'd2,
        OP_DM_WR = 3'd3,
        OP_BSET  = 3'd4,
        OP_BCLR  = 3'd5,
        OP_BTST  = 3'd6,
        OP_NONE  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        BA_RW  = 2'd0,
        BA_RO  = 2'd1,
        BA_W1C = 2'd2,
        BA_RSV = 2'd3
    } battr_e;

    // True for registers that must never be written
    function automatic logic addr_reserved(input logic [IO_ADDR_W-1:0] a);
        return a[3:0] == 4'hF;
    endfunction

    // Kind of bit b in register a
    function automatic battr_e bit_attr(input int unsigned a, input int unsigned b);
        battr_e k;
        case (a % 16)
            15: k = BA_RSV;
            8: begin
                if (b >= 4)      k = BA_W1C;
                else if (b >= 2) k = BA_RW;
                else if (b == 1) k = BA_RO;
                else             k = BA_RSV;
            end
            9:  k = BA_RO;
            14: k = (b >= 6) ? BA_RSV : BA_RW;
            default: k = BA_RW;
        endcase
        return k;
    endfunction

    // Mask of the bits of register a that have kind k
    function automatic byte_t attr_mask(input int unsigned a, input battr_e k);
        byte_t m;
        m = '0;
        for (int b = 0; b < IO_DATA_W; b++) begin
            m[b] = (bit_attr(a, b) == k);
        end
        return m;
    endfunction
endpackage

// File: rtl/dwio_decode.sv
// Module: request decoder. Maps both address windows onto one register
// index, classifies the operation and flags refused requests.
// Assumes at most one request per cycle; all outputs are combinational.
module dwio_decode
    import dwio_pkg::*;
#(
    parameter int DM_ADDR_W  = 16,
    parameter int DM_BASE    = 32,
    parameter int BITOP_REGS = 32
) (
    input  logic                 req_valid,
    input  logic [2:0]           req_op,
    input  logic [DM_ADDR_W-1:0] req_addr,
    output logic [IO_ADDR_W-1:0] idx,
    output logic                 do_rd,
    output logic                 do_wr,
    output logic                 do_set,
    output logic                 do_clr,
    output logic                 do_tst,
    output logic                 err
);
    localparam logic [DM_ADDR_W-1:0] IO_LIM  = DM_ADDR_W'(IO_REGS);
    localparam logic [DM_ADDR_W-1:0] DM_LO   = DM_ADDR_W'(DM_BASE);
    localparam logic [DM_ADDR_W-1:0] DM_HI   = DM_ADDR_W'(DM_BASE + IO_REGS);
    localparam logic [DM_ADDR_W-1:0] BIT_LIM = DM_ADDR_W'(BITOP_REGS);

    logic in_io, in_dm, in_bit, rsv, is_dm;
    op_e  op;

    // Window hits and register index selection
    always_comb begin
        op     = op_e'(req_op);
        in_io  = req_addr < IO_LIM;
        in_dm  = (req_addr >= DM_LO) && (req_addr < DM_HI);
        in_bit = req_addr < BIT_LIM;
        is_dm  = (op == OP_DM_RD) || (op == OP_DM_WR);
        idx    = is_dm ? IO_ADDR_W'(req_addr - DM_LO) : req_addr[IO_ADDR_W-1:0];
        rsv    = addr_reserved(idx);
    end

    // Operation classification and refusal reporting
    always_comb begin
        do_rd = 1'b0; do_wr = 1'b0; do_set = 1'b0;
        do_clr = 1'b0; do_tst = 1'b0; err = 1'b0;
        if (req_valid) begin
            case (op)
                OP_IO_RD: do_rd = in_io;
                OP_DM_RD: do_rd = in_dm;
                OP_IO_WR, OP_DM_WR: begin
                    if ((op == OP_IO_WR) ? in_io : in_dm) begin
                        err   = rsv;
                        do_wr = !rsv;
                    end
                end
                OP_BSET, OP_BCLR: begin
                    err    = !in_bit || rsv;
                    do_set = in_bit && !rsv && (op == OP_BSET);
                    do_clr = in_bit && !rsv && (op == OP_BCLR);
                end
                OP_BTST: begin
                    err    = !in_bit;
                    do_tst = in_bit;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dwio_row.sv
// Module: one register of the bank. Applies core writes and bit operations
// according to the fixed attribute masks of ROW_IDX, then peripheral loads
// and flag sets, which take priority. Reserved bits are held at zero.
module dwio_row
    import dwio_pkg::*;
#(
    parameter int ROW_IDX = 0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cpu_wr,
    input  logic  cpu_set,
    input  logic  cpu_clr,
    input  byte_t wdata,
    input  byte_t bit_sel,
    input  byte_t hw_set,
    input  logic  hw_load,
    input  byte_t hw_data,
    output byte_t q
);
    localparam byte_t RW_M  = attr_mask(ROW_IDX, BA_RW);
    localparam byte_t RO_M  = attr_mask(ROW_IDX, BA_RO);
    localparam byte_t W1C_M = attr_mask(ROW_IDX, BA_W1C);
    localparam byte_t KEEP  = RW_M | RO_M | W1C_M;

    byte_t nxt;

    // Next value: core effect first, then peripheral effects override
    always_comb begin
        nxt = q;
        if (cpu_wr) begin
            nxt = (wdata & RW_M) | (q & RO_M) | (q & W1C_M & ~wdata);
        end else if (cpu_set) begin
            nxt = (q | (bit_sel & RW_M)) & ~(bit_sel & W1C_M);
        end else if (cpu_clr) begin
            nxt = q & ~(bit_sel & RW_M);
        end
        if (hw_load) begin
            nxt = (nxt & ~RO_M) | (hw_data & RO_M);
        end
        nxt = (nxt | (hw_set & W1C_M)) & KEEP;
    end

    // Register storage
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/dwio_top.sv
// Module: dual-window I/O register bank. Decodes core requests from the
// direct and data-memory windows, fans them out to 64 register rows and
// returns read, bit-test and error results one clock edge later.
// Assumes a single clock domain and one core request per cycle.
module dwio_top
    import dwio_pkg::*;
#(
    parameter int DM_ADDR_W  = 16,
    parameter int DM_BASE    = 32,
    parameter int BITOP_REGS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [2:0]           req_op,
    input  logic [DM_ADDR_W-1:0] req_addr,
    input  logic [IO_BIT_W-1:0]  req_bit,
    input  logic [IO_DATA_W-1:0] req_wdata,
    input  logic [IO_ADDR_W-1:0] hw_addr,
    input  logic [IO_DATA_W-1:0] hw_flag_set,
    input  logic                 hw_ro_load,
    input  logic [IO_DATA_W-1:0] hw_ro_data,
    output logic                 rd_valid,
    output logic [IO_DATA_W-1:0] rd_data,
    output logic                 tst_valid,
    output logic                 tst_bit,
    output logic                 err_strobe
);
    logic [IO_ADDR_W-1:0] idx;
    logic  do_rd, do_wr, do_set, do_clr, do_tst, dec_err;
    byte_t bit_sel;
    byte_t row_q [IO_REGS];

    dwio_decode #(
        .DM_ADDR_W (DM_ADDR_W),
        .DM_BASE   (DM_BASE),
        .BITOP_REGS(BITOP_REGS)
    ) u_dec (
        .req_valid(req_valid),
        .req_op   (req_op),
        .req_addr (req_addr),
        .idx      (idx),
        .do_rd    (do_rd),
        .do_wr    (do_wr),
        .do_set   (do_set),
        .do_clr   (do_clr),
        .do_tst   (do_tst),
        .err      (dec_err)
    );

    // One-hot mask of the addressed bit
    always_comb bit_sel = byte_t'(1) << req_bit;

    for (genvar r = 0; r < IO_REGS; r++) begin : g_row
        logic sel, hsel;
        assign sel  = (idx == IO_ADDR_W'(r));
        assign hsel = (hw_addr == IO_ADDR_W'(r));
        dwio_row #(.ROW_IDX(r)) u_row (
            .clk    (clk),
            .rst_n  (rst_n),
            .cpu_wr (do_wr && sel),
            .cpu_set(do_set && sel),
            .cpu_clr(do_clr && sel),
            .wdata  (req_wdata),
            .bit_sel(bit_sel),
            .hw_set (hsel ? hw_flag_set : '0),
            .hw_load(hw_ro_load && hsel),
            .hw_data(hw_ro_data),
            .q      (row_q[r])
        );
    end

    // Registered response: read byte, test bit and error strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            tst_valid  <= 1'b0;
            tst_bit    <= 1'b0;
            err_strobe <= 1'b0;
        end else begin
            rd_valid   <= do_rd || do_tst;
            rd_data    <= (do_rd || do_tst) ? row_q[idx] : '0;
            tst_valid  <= do_tst;
            tst_bit    <= do_tst && row_q[idx][req_bit];
            err_strobe <= dec_err;
        end
    end
endmodule

// File: rtl/dwio_checker.sv
// Module: protocol checker for dwio_top, attached by bind. Relates
// requests at the ports to the responses one edge later.
module dwio_checker #(
    parameter int DM_ADDR_W  = 16,
    parameter int DM_BASE    = 32,
    parameter int BITOP_REGS = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [2:0]           req_op,
    input logic [DM_ADDR_W-1:0] req_addr,
    input logic [2:0]           req_bit,
    input logic                 rd_valid,
    input logic [7:0]           rd_data,
    input logic                 tst_valid,
    input logic                 tst_bit,
    input logic                 err_strobe
);
    logic io_in, dm_in, rsv_io;
    assign io_in  = req_addr < DM_ADDR_W'(64);
    assign dm_in  = (req_addr >= DM_ADDR_W'(DM_BASE)) && (req_addr < DM_ADDR_W'(DM_BASE + 64));
    assign rsv_io = io_in && (req_addr[3:0] == 4'hF);

    AST_IO_READ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == 3'd0 && io_in |=> rd_valid && !err_strobe); // R1
    AST_DM_READ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == 3'd2 && dm_in |=> rd_valid); // R2
    AST_DM_OUTSIDE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_op == 3'd2 || req_op == 3'd3) && !dm_in |=> !rd_valid && !err_strobe); // R3
    AST_BITOP_RANGE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (req_op >= 3'd4 && req_op <= 3'd6) && req_addr >= DM_ADDR_W'(BITOP_REGS)
        |=> err_strobe && !rd_valid); // R4
    AST_TST_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        tst_valid |-> rd_valid && (tst_bit == rd_data[$past(req_bit)])); // R5
    AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == 3'd0 && rsv_io |=> rd_data == 8'h00); // R8
    AST_RSV_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == 3'd1 && rsv_io |=> err_strobe); // R9
    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_strobe |-> $past(req_valid)); // R9
endmodule

bind dwio_top dwio_checker #(
    .DM_ADDR_W (DM_ADDR_W),
    .DM_BASE   (DM_BASE),
    .BITOP_REGS(BITOP_REGS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_bit   (req_bit),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .tst_valid (tst_valid),
    .tst_bit   (tst_bit),
    .err_strobe(err_strobe)
);

// File: tb/sim_dwio_top.sv
// Bench: directed corner cases plus seeded random requests, checked
// against a bench model of the register bank built from the requirements.
module sim_dwio_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd7;
    logic [15:0] req_addr = '0;
    logic [2:0]  req_bit = '0;
    logic [7:0]  req_wdata = '0;
    logic [5:0]  hw_addr = '0;
    logic [7:0]  hw_flag_set = '0;
    logic        hw_ro_load = 1'b0;
    logic [7:0]  hw_ro_data = '0;
    logic        rd_valid, tst_valid, tst_bit, err_strobe;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] m [64];

    always #2 clk = ~clk;

    dwio_top u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_bit(req_bit), .req_wdata(req_wdata),
        .hw_addr(hw_addr), .hw_flag_set(hw_flag_set), .hw_ro_load(hw_ro_load),
        .hw_ro_data(hw_ro_data), .rd_valid(rd_valid), .rd_data(rd_data),
        .tst_valid(tst_valid), .tst_bit(tst_bit), .err_strobe(err_strobe)
    );

    // Bit kind per R6, R8, R9, R11: 0 rw, 1 ro, 2 flag, 3 reserved
    function automatic int kind(input int a, input int b);
        int lo = a % 16;
        if (lo == 15) return 3;
        if (lo == 9)  return 1;
        if (lo == 14) return (b >= 6) ? 3 : 0;
        if (lo == 8) begin
            if (b >= 4) return 2;
            if (b >= 2) return 0;
            if (b == 1) return 1;
            return 3;
        end
        return 0;
    endfunction

    function automatic logic [7:0] kmask(input int a, input int k);
        logic [7:0] r = '0;
        for (int b = 0; b < 8; b++) r[b] = (kind(a, b) == k);
        return r;
    endfunction

    task automatic chk(input logic ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // One request (optionally with peripheral activity), response checked one edge later
    task automatic run_op(input int op, input int addr, input int bs, input int wd,
                          input int ha, input int hset, input int hload, input int hdata,
                          input string tag);
        logic e_rd = 0, e_tst = 0, e_err = 0, e_tb = 0, in_win = 0;
        logic [7:0] e_d = '0, rw, ro, fl, q;
        int idx = 0;
        @(negedge clk);
        req_valid = 1; req_op = 3'(op); req_addr = 16'(addr); req_bit = 3'(bs);
        req_wdata = 8'(wd); hw_addr = 6'(ha); hw_flag_set = 8'(hset);
        hw_ro_load = 1'(hload); hw_ro_data = 8'(hdata);
        case (op)
            0, 1: begin in_win = addr < 64; idx = addr % 64; end
            2, 3: begin in_win = addr >= 32 && addr < 96; idx = (addr - 32) & 63; end
            4, 5, 6: begin in_win = addr < 32; idx = addr % 64; end
            default: ;
        endcase
        rw = kmask(idx, 0); ro = kmask(idx, 1); fl = kmask(idx, 2);
        q = m[idx];
        e_d = q; e_tb = q[bs];
        if ((op == 0 || op == 2) && in_win) e_rd = 1;
        if ((op == 1 || op == 3) && in_win) begin
            if (idx % 16 == 15) e_err = 1;
            else m[idx] = (8'(wd) & rw) | (q & ro) | (q & fl & ~8'(wd));
        end
        if (op == 4 || op == 5) begin
            if (!in_win || idx % 16 == 15) e_err = 1;
            else if (op == 4) begin
                if (rw[bs]) m[idx][bs] = 1'b1;
                if (fl[bs]) m[idx][bs] = 1'b0;
            end else if (rw[bs]) m[idx][bs] = 1'b0;
        end
        if (op == 6) begin
            if (!in_win) e_err = 1;
            else begin e_rd = 1; e_tst = 1; end
        end
        if (hload != 0) m[ha] = (m[ha] & ~kmask(ha, 1)) | (8'(hdata) & kmask(ha, 1));
        m[ha] = m[ha] | (8'(hset) & kmask(ha, 2));
        @(negedge clk);
        chk(rd_valid === e_rd, tag, "rd_valid", int'(rd_valid), int'(e_rd));
        chk(err_strobe === e_err, tag, "err_strobe", int'(err_strobe), int'(e_err));
        chk(tst_valid === e_tst, tag, "tst_valid", int'(tst_valid), int'(e_tst));
        if (e_rd) chk(rd_data === e_d, tag, "rd_data", int'(rd_data), int'(e_d));
        if (e_tst) chk(tst_bit === e_tb, tag, "tst_bit", int'(tst_bit), int'(e_tb));
        req_valid = 0; req_op = 3'd7; hw_flag_set = '0; hw_ro_load = 0;
    endtask

    task automatic io_rd(input int a, input string tag);
        run_op(0, a, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) m[i] = '0;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R12: outputs quiet during reset
        chk(rd_valid === 0 && err_strobe === 0 && tst_valid === 0, "R12", "outputs in reset",
            int'({rd_valid, err_strobe, tst_valid}), 0);
        rst_n = 1;
        for (int a = 0; a < 64; a++) io_rd(a, "R12");

        // R1 direct write/read, R2 data window aliasing
        run_op(1, 8'h05, 0, 8'hA5, 0, 0, 0, 0, "R1");
        io_rd(8'h05, "R1");
        run_op(2, 8'h25, 0, 0, 0, 0, 0, 0, "R2");
        run_op(3, 8'h5E, 0, 8'hFF, 0, 0, 0, 0, "R2");
        io_rd(8'h3E, "R8");
        run_op(0, 8'h45, 0, 0, 0, 0, 0, 0, "R1");
        // R3 outside data window
        run_op(3, 8'h60, 0, 8'h77, 0, 0, 0, 0, "R3");
        run_op(3, 8'h1F, 0, 8'h77, 0, 0, 0, 0, "R3");
        run_op(2, 8'h1E, 0, 0, 0, 0, 0, 0, "R3");
        io_rd(8'h00, "R3");
        // R6 flag register
        run_op(7, 0, 0, 0, 8'h08, 8'hF0, 0, 0, "R10");
        io_rd(8'h08, "R10");
        run_op(1, 8'h08, 0, 8'h5C, 0, 0, 0, 0, "R6");
        io_rd(8'h08, "R6");
        // R7 bit operations on flags
        run_op(4, 8'h08, 7, 0, 0, 0, 0, 0, "R7");
        run_op(5, 8'h08, 5, 0, 0, 0, 0, 0, "R7");
        run_op(5, 8'h08, 2, 0, 0, 0, 0, 0, "R4");
        run_op(4, 8'h08, 0, 0, 0, 0, 0, 0, "R8");
        io_rd(8'h08, "R7");
        // R5 bit tests
        run_op(6, 8'h08, 5, 0, 0, 0, 0, 0, "R5");
        run_op(6, 8'h08, 7, 0, 0, 0, 0, 0, "R5");
        // R4 out of range bit operations
        run_op(1, 8'h20, 0, 8'h00, 0, 0, 0, 0, "R4");
        run_op(4, 8'h20, 0, 0, 0, 0, 0, 0, "R4");
        run_op(6, 8'h21, 0, 0, 0, 0, 0, 0, "R4");
        io_rd(8'h20, "R4");
        // R9 reserved addresses
        run_op(1, 8'h0F, 0, 8'hFF, 0, 0, 0, 0, "R9");
        run_op(3, 8'h2F, 0, 8'hFF, 0, 0, 0, 0, "R9");
        run_op(4, 8'h1F, 3, 0, 0, 0, 0, 0, "R9");
        io_rd(8'h0F, "R9");
        // R10 set beats simultaneous clear
        run_op(1, 8'h18, 0, 8'h20, 8'h18, 8'h20, 0, 0, "R10");
        run_op(7, 0, 0, 0, 8'h18, 8'h10, 0, 0, "R10");
        run_op(4, 8'h18, 4, 0, 8'h18, 8'h10, 0, 0, "R10");
        io_rd(8'h18, "R10");
        // R11 read-only bits
        run_op(1, 8'h09, 0, 8'hFF, 0, 0, 0, 0, "R11");
        io_rd(8'h09, "R11");
        run_op(7, 0, 0, 0, 8'h09, 0, 1, 8'h5A, "R11");
        run_op(4, 8'h09, 0, 0, 0, 0, 0, 0, "R11");
        io_rd(8'h09, "R11");
        run_op(1, 8'h08, 0, 8'h02, 8'h08, 0, 1, 8'h02, "R11");
        io_rd(8'h08, "R11");

        // Seeded random mix
        for (int n = 0; n < 1500; n++) begin
            int op = $urandom_range(0, 7);
            int ad = (op >= 4 && op <= 6) ? $urandom_range(0, 47)
                   : (op == 2 || op == 3) ? $urandom_range(0, 127) : $urandom_range(0, 79);
            int hw = ($urandom_range(0, 3) == 0);
            string t = (op == 2 || op == 3) ? "R2" : (op >= 4 && op <= 6) ? "R4" : "R1";
            run_op(op, ad, $urandom_range(0, 7), $urandom_range(0, 255),
                   $urandom_range(0, 63), hw ? $urandom_range(0, 255) : 0,
                   hw ? $urandom_range(0, 1) : 0, $urandom_range(0, 255), t);
        end
        for (int a = 0; a < 64; a++) io_rd(a, "R6");
        finish_run();
    end
endmodule